// File: doc/BRIEF.md
# Receive Clock and Level Acquisition Sequencer

This block is the control state machine that sits beside a four-level FSK receive modem. When a channel opens, it first puts the modem's symbol-timing loop into its wide-bandwidth setting and selects continuous level tracking. It then waits until the carrier has been present for a run of symbol times. That wait gives the received signal time to pass through the receive filter. After the wait, it writes one search command with both acquisition enables set: one for symbol clock, one for level. When the modem signals a frame-sync match or a finished task, the sequencer narrows the timing loop to medium bandwidth and reports lock.

While lock holds, each frame-read request from the host becomes a search command with both acquisition enables clear. The loop stays at medium bandwidth and level tracking stays on. Lock is lost in either of two ways: the host signals a channel change, or carrier stays absent for a run of symbol times. Either way the block goes back to wide bandwidth, and the next search command sets both acquisition enables again.

A second mode serves links that have no carrier detect and that send each frame behind a long symbol-sync preamble. In this mode a host start request launches acquisition at once, and carrier is ignored both for qualification and for loss.

States:
- `ST_IDLE`: the block is disabled.
- `ST_QUALIFY`: the block is counting carrier symbols, or waiting for a start request in no-carrier-detect mode.
- `ST_ACQ_WAIT`: an acquiring command has been issued and the block awaits the interrupt.
- `ST_LOCKED`: lock is held and no command is outstanding.
- `ST_READ_WAIT`: a non-acquiring command has been issued and the block awaits the interrupt.

Transitions:
- Disable goes from any state to `ST_IDLE`.
- Enable goes from `ST_IDLE` to `ST_QUALIFY`.
- A channel change from any enabled state, or a carrier-loss run, returns the block to `ST_QUALIFY`.
- Qualification or a start request goes from `ST_QUALIFY` to `ST_ACQ_WAIT`.
- An interrupt goes from `ST_ACQ_WAIT` to `ST_LOCKED`.
- A host read goes from `ST_LOCKED` to `ST_READ_WAIT`.
- An interrupt goes from `ST_READ_WAIT` back to `ST_LOCKED`.

Top module: `fsk_acq_sequencer`

## Requirements
- R1: While reset is high, and in the cycle after it is released, pll_bw reads 2'b00 (wide), lev_track reads 1, cmd_valid reads 0 and locked reads 0.
- R2: With carrier detect in use, cmd_valid pulses for one cycle after the 8th consecutive sym_tick taken with carrier high, and this command has cmd_aqsc=1 and cmd_aqlev=1. After only 7 such ticks no command is issued.
- R3: Carrier going low in any cycle during qualification restarts the count, so a further 8 ticks with carrier are needed.
- R4: The command task code is captured from read_sel in the cycle the command is issued: 0 gives 4'h1 (frame-sync search) and 1 gives 4'h2 (frame search and read).
- R5: A modem_irq while awaiting the acquisition result sets pll_bw to 2'b01 (medium) and locked to 1 in the next cycle.
- R6: While locked, a host_read issues one command with cmd_aqsc=0 and cmd_aqlev=0, while pll_bw stays 2'b01 and lev_track stays 1.
- R7: Only one command is ever outstanding. host_read or host_start while a command awaits its interrupt produces no strobe, and cmd_valid is never high in two consecutive cycles.
- R8: With no_cd_mode=1, host_start issues the acquiring command directly, sym_tick with carrier starts nothing, and carrier absence does not drop lock.
- R9: While in an acquisition-wait, locked or read-wait state with carrier detect in use, 8 consecutive sym_ticks with carrier low clear locked and return pll_bw to 2'b00. Seven such ticks do not. The next command after requalification has both acquisition bits at 1.
- R10: chan_change while enabled clears locked, sets pll_bw to 2'b00 in the next cycle and restarts qualification.
- R11: enable low forces the idle state (wide, unlocked) in which no command is issued. Raising enable starts a fresh qualification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Receive sequencer enable |
| no_cd_mode | input | 1 | 1 = acquisition on host start, carrier ignored |
| carrier | input | 1 | Carrier-detect level |
| sym_tick | input | 1 | One-cycle pulse per received symbol |
| host_start | input | 1 | Start request used in no-carrier-detect mode |
| host_read | input | 1 | Request for the next frame read |
| read_sel | input | 1 | Task select: 0 sync search, 1 search and read |
| chan_change | input | 1 | Host switched channel |
| modem_irq | input | 1 | Frame-sync recognised or task complete |
| pll_bw | output | 2 | Loop bandwidth: 00 wide, 01 medium |
| lev_track | output | 1 | Level mode, 1 = level track |
| cmd_valid | output | 1 | One-cycle command write strobe |
| cmd_task | output | 4 | Task code of the command |
| cmd_aqsc | output | 1 | Symbol-clock acquisition enable |
| cmd_aqlev | output | 1 | Level acquisition enable |
| locked | output | 1 | Lock status |

## Verification
The bench goes after the edges of both symbol runs. It checks that seven ticks are not enough and eight are, and that a single carrier-low cycle in the middle of a run restarts it. A counter that was off by one, or that only paused on a dropout, would issue the command early. The bench also requests reads while a command is still outstanding and repeats loss after lock; a design that failed to gate these would emit a second strobe or keep stale medium bandwidth with acquisition bits clear. It further checks no-carrier-detect mode, where a design that still consulted carrier would start or drop lock on its own.

// File: rtl/fskacq_pkg.sv
package fskacq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_QUALIFY,
        ST_ACQ_WAIT,
        ST_LOCKED,
        ST_READ_WAIT
    } acq_state_t;

    typedef enum logic [1:0] {
        BW_WIDE   = 2'b00,
        BW_MEDIUM = 2'b01,
        BW_NARROW = 2'b10
    } pll_bw_t;

endpackage

// File: rtl/sym_run_counter.sv
module sym_run_counter #(
    parameter int RUN_LEN = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic level,
    input  logic tick,
    output logic hit
);
    localparam int CW = $clog2(RUN_LEN + 1);

    logic [CW-1:0] cnt_q;

    assign hit = level && tick && !clr && (cnt_q == CW'(RUN_LEN - 1));

    always_ff @(posedge clk) begin
        if (rst || clr || !level) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (hit) cnt_q <= '0;
            else     cnt_q <= cnt_q + CW'(1);
        end
    end

    // R2 / R9: the run count never reaches the run length
    p_run_bound_r2: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CW'(RUN_LEN));

endmodule

// File: rtl/acq_fsm.sv
module acq_fsm
    import fskacq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       no_cd_mode,
    input  logic       host_start,
    input  logic       host_read,
    input  logic       chan_change,
    input  logic       modem_irq,
    input  logic       qual_hit,
    input  logic       loss_hit,
    output acq_state_t state_q,
    output acq_state_t state_nxt,
    output logic       issue,
    output logic       issue_acq
);
    logic start_ok;

    assign start_ok = no_cd_mode ? host_start : qual_hit;

    always_comb begin
        state_nxt = state_q;
        issue     = 1'b0;
        issue_acq = 1'b0;
        if (!enable) begin
            state_nxt = ST_IDLE;
        end else if (chan_change && state_q != ST_IDLE) begin
            state_nxt = ST_QUALIFY;
        end else if (loss_hit) begin
            state_nxt = ST_QUALIFY;
        end else begin
            unique case (state_q)
                ST_IDLE: state_nxt = ST_QUALIFY;
                ST_QUALIFY: begin
                    if (start_ok) begin
                        state_nxt = ST_ACQ_WAIT;
                        issue     = 1'b1;
                        issue_acq = 1'b1;
                    end
                end
                ST_ACQ_WAIT:  if (modem_irq) state_nxt = ST_LOCKED;
                ST_LOCKED: begin
                    if (host_read) begin
                        state_nxt = ST_READ_WAIT;
                        issue     = 1'b1;
                    end
                end
                ST_READ_WAIT: if (modem_irq) state_nxt = ST_LOCKED;
                default:      state_nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_nxt;
    end

    // R7: a new command is only issued from a state with none outstanding
    p_issue_from_free_r7: assert property (@(posedge clk) disable iff (rst)
        issue |-> (state_q == ST_QUALIFY || state_q == ST_LOCKED));

endmodule

// File: rtl/acq_cmd_out.sv
module acq_cmd_out
    import fskacq_pkg::*;
#(
    parameter int          TASK_W      = 4,
    parameter logic [TASK_W-1:0] TASK_SEARCH = 4'h1,
    parameter logic [TASK_W-1:0] TASK_READ   = 4'h2
) (
    input  logic              clk,
    input  logic              rst,
    input  acq_state_t        state_nxt,
    input  logic              issue,
    input  logic              issue_acq,
    input  logic              read_sel,
    output pll_bw_t           pll_bw,
    output logic              lev_track,
    output logic              cmd_valid,
    output logic [TASK_W-1:0] cmd_task,
    output logic              cmd_aqsc,
    output logic              cmd_aqlev,
    output logic              locked
);
    logic lock_nxt;

    assign lock_nxt = (state_nxt == ST_LOCKED) || (state_nxt == ST_READ_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            pll_bw    <= BW_WIDE;
            lev_track <= 1'b1;
            cmd_valid <= 1'b0;
            cmd_task  <= '0;
            cmd_aqsc  <= 1'b0;
            cmd_aqlev <= 1'b0;
            locked    <= 1'b0;
        end else begin
            pll_bw    <= lock_nxt ? BW_MEDIUM : BW_WIDE;
            lev_track <= 1'b1;
            locked    <= lock_nxt;
            cmd_valid <= issue;
            cmd_aqsc  <= issue && issue_acq;
            cmd_aqlev <= issue && issue_acq;
            if (issue) cmd_task <= read_sel ? TASK_READ : TASK_SEARCH;
        end
    end

    // R7: a strobe never lasts two cycles
    p_one_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

endmodule

// File: rtl/fsk_acq_sequencer.sv
module fsk_acq_sequencer
    import fskacq_pkg::*;
#(
    parameter int QUAL_SYMS = 8,
    parameter int LOSS_SYMS = 8,
    parameter int TASK_W    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              no_cd_mode,
    input  logic              carrier,
    input  logic              sym_tick,
    input  logic              host_start,
    input  logic              host_read,
    input  logic              read_sel,
    input  logic              chan_change,
    input  logic              modem_irq,
    output logic [1:0]        pll_bw,
    output logic              lev_track,
    output logic              cmd_valid,
    output logic [TASK_W-1:0] cmd_task,
    output logic              cmd_aqsc,
    output logic              cmd_aqlev,
    output logic              locked
);
    acq_state_t state_q, state_nxt;
    pll_bw_t    bw_enc;
    logic       issue, issue_acq;
    logic       qual_hit, loss_hit;
    logic       qual_clr, loss_clr;
    logic       in_hold;

    assign in_hold  = (state_q == ST_ACQ_WAIT) || (state_q == ST_LOCKED) ||
                      (state_q == ST_READ_WAIT);
    assign qual_clr = (state_q != ST_QUALIFY) || chan_change || no_cd_mode;
    assign loss_clr = !in_hold || no_cd_mode || chan_change;

    sym_run_counter #(.RUN_LEN(QUAL_SYMS)) u_qual (
        .clk(clk), .rst(rst), .clr(qual_clr), .level(carrier),
        .tick(sym_tick), .hit(qual_hit)
    );

    sym_run_counter #(.RUN_LEN(LOSS_SYMS)) u_loss (
        .clk(clk), .rst(rst), .clr(loss_clr), .level(!carrier),
        .tick(sym_tick), .hit(loss_hit)
    );

    acq_fsm u_fsm (
        .clk(clk), .rst(rst), .enable(enable), .no_cd_mode(no_cd_mode),
        .host_start(host_start), .host_read(host_read),
        .chan_change(chan_change), .modem_irq(modem_irq),
        .qual_hit(qual_hit), .loss_hit(loss_hit),
        .state_q(state_q), .state_nxt(state_nxt),
        .issue(issue), .issue_acq(issue_acq)
    );

    acq_cmd_out #(.TASK_W(TASK_W)) u_out (
        .clk(clk), .rst(rst), .state_nxt(state_nxt), .issue(issue),
        .issue_acq(issue_acq), .read_sel(read_sel), .pll_bw(bw_enc),
        .lev_track(lev_track), .cmd_valid(cmd_valid), .cmd_task(cmd_task),
        .cmd_aqsc(cmd_aqsc), .cmd_aqlev(cmd_aqlev), .locked(locked)
    );

    assign pll_bw = bw_enc;

    // R2: commands launched from qualification carry both acquisition bits
    p_acq_bits_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && $past(state_q) == ST_QUALIFY) |-> (cmd_aqsc && cmd_aqlev));

    // R6: reads issued under lock carry no acquisition bits
    p_read_noacq_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && $past(state_q) == ST_LOCKED) |-> (!cmd_aqsc && !cmd_aqlev));

    // R5: lock only rises after a modem interrupt
    p_lock_on_irq_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(modem_irq));

    // R10: channel change drops to wide and unlocked
    p_chan_wide_r10: assert property (@(posedge clk) disable iff (rst)
        (chan_change && enable) |=> (pll_bw == 2'b00 && !locked));

    // R9: a carrier-loss run clears lock
    p_loss_drop_r9: assert property (@(posedge clk) disable iff (rst)
        loss_hit |=> !locked);

endmodule

// File: tb/fsk_acq_sequencer_bench.sv
module fsk_acq_sequencer_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0, no_cd_mode = 1'b0, carrier = 1'b0, sym_tick = 1'b0;
    logic       host_start = 1'b0, host_read = 1'b0, read_sel = 1'b0;
    logic       chan_change = 1'b0, modem_irq = 1'b0;
    logic [1:0] pll_bw;
    logic       lev_track, cmd_valid, cmd_aqsc, cmd_aqlev, locked;
    logic [3:0] cmd_task;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    fsk_acq_sequencer u_fsk_acq_sequencer (
        .clk(clk), .rst(rst), .enable(enable), .no_cd_mode(no_cd_mode),
        .carrier(carrier), .sym_tick(sym_tick), .host_start(host_start),
        .host_read(host_read), .read_sel(read_sel), .chan_change(chan_change),
        .modem_irq(modem_irq), .pll_bw(pll_bw), .lev_track(lev_track),
        .cmd_valid(cmd_valid), .cmd_task(cmd_task), .cmd_aqsc(cmd_aqsc),
        .cmd_aqlev(cmd_aqlev), .locked(locked)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_cycle();
        @(negedge clk);
    endtask

    task automatic tick();
        sym_tick = 1'b1;
        @(negedge clk);
        sym_tick = 1'b0;
    endtask

    task automatic ticks_no_cmd(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            tick();
            chk(req, {31'd0, cmd_valid}, 32'd0);
        end
    endtask

    task automatic pulse_irq();
        modem_irq = 1'b1;
        @(negedge clk);
        modem_irq = 1'b0;
    endtask

    task automatic pulse_chan();
        chan_change = 1'b1;
        @(negedge clk);
        chan_change = 1'b0;
    endtask

    task automatic pulse_read();
        host_read = 1'b1;
        @(negedge clk);
        host_read = 1'b0;
    endtask

    task automatic expect_acq_cmd(input string req, input logic [3:0] task_code);
        chk(req, {31'd0, cmd_valid}, 32'd1);
        chk(req, {30'd0, cmd_aqsc, cmd_aqlev}, 32'd3);
        chk(req, {28'd0, cmd_task}, {28'd0, task_code});
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 bw in reset", {30'd0, pll_bw}, 32'd0);
        chk("R1 lev in reset", {31'd0, lev_track}, 32'd1);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 bw", {30'd0, pll_bw}, 32'd0);
        chk("R1 cmd", {31'd0, cmd_valid}, 32'd0);
        chk("R1 locked", {31'd0, locked}, 32'd0);
    endtask

    task automatic t_qualify();
        enable = 1'b1; carrier = 1'b1; read_sel = 1'b0;
        idle_cycle();
        ticks_no_cmd(7, "R2 early");
        tick();
        expect_acq_cmd("R2 R4 first cmd", 4'h1);
        idle_cycle();
        chk("R7 single strobe", {31'd0, cmd_valid}, 32'd0);
    endtask

    task automatic t_busy_ignore();
        pulse_read();
        chk("R7 read while waiting", {31'd0, cmd_valid}, 32'd0);
        host_start = 1'b1; @(negedge clk); host_start = 1'b0;
        chk("R7 start while waiting", {31'd0, cmd_valid}, 32'd0);
    endtask

    task automatic t_lock();
        chk("R5 wide before irq", {30'd0, pll_bw}, 32'd0);
        pulse_irq();
        chk("R5 medium", {30'd0, pll_bw}, 32'd1);
        chk("R5 locked", {31'd0, locked}, 32'd1);
    endtask

    task automatic t_read();
        read_sel = 1'b1;
        pulse_read();
        chk("R6 read cmd", {31'd0, cmd_valid}, 32'd1);
        chk("R6 no acq bits", {30'd0, cmd_aqsc, cmd_aqlev}, 32'd0);
        chk("R4 read task", {28'd0, cmd_task}, 32'd2);
        chk("R6 bw medium", {30'd0, pll_bw}, 32'd1);
        chk("R6 lev track", {31'd0, lev_track}, 32'd1);
        pulse_read();
        chk("R7 second read", {31'd0, cmd_valid}, 32'd0);
        pulse_irq();
        chk("R6 still locked", {31'd0, locked}, 32'd1);
        read_sel = 1'b0;
    endtask

    task automatic t_loss();
        carrier = 1'b0;
        for (int i = 0; i < 7; i++) tick();
        chk("R9 seven lost ticks", {31'd0, locked}, 32'd1);
        tick();
        chk("R9 unlocked", {31'd0, locked}, 32'd0);
        chk("R9 wide", {30'd0, pll_bw}, 32'd0);
        carrier = 1'b1;
        ticks_no_cmd(7, "R9 requalify early");
        tick();
        expect_acq_cmd("R9 reacquire", 4'h1);
        pulse_irq();
    endtask

    task automatic t_chan();
        pulse_chan();
        chk("R10 wide", {30'd0, pll_bw}, 32'd0);
        chk("R10 unlocked", {31'd0, locked}, 32'd0);
        ticks_no_cmd(7, "R10 requalify early");
        tick();
        expect_acq_cmd("R10 reacquire", 4'h1);
    endtask

    task automatic t_restart();
        pulse_chan();
        for (int i = 0; i < 5; i++) tick();
        carrier = 1'b0; @(negedge clk); carrier = 1'b1;
        ticks_no_cmd(7, "R3 restarted count");
        tick();
        expect_acq_cmd("R3 after restart", 4'h1);
    endtask

    task automatic t_nocd();
        pulse_chan();
        no_cd_mode = 1'b1;
        ticks_no_cmd(10, "R8 ticks ignored");
        read_sel = 1'b1;
        host_start = 1'b1; @(negedge clk); host_start = 1'b0;
        expect_acq_cmd("R8 start cmd", 4'h2);
        read_sel = 1'b0;
        pulse_irq();
        carrier = 1'b0;
        for (int i = 0; i < 10; i++) tick();
        chk("R8 no loss", {31'd0, locked}, 32'd1);
    endtask

    task automatic t_enable();
        enable = 1'b0; no_cd_mode = 1'b0; carrier = 1'b1;
        idle_cycle();
        chk("R11 idle wide", {30'd0, pll_bw}, 32'd0);
        chk("R11 idle unlocked", {31'd0, locked}, 32'd0);
        ticks_no_cmd(10, "R11 idle no cmd");
        enable = 1'b1;
        idle_cycle();
        ticks_no_cmd(7, "R11 fresh count");
        tick();
        expect_acq_cmd("R11 cmd after enable", 4'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_qualify();
        t_busy_ignore();
        t_lock();
        t_read();
        t_loss();
        t_chan();
        t_restart();
        t_nocd();
        t_enable();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule